// File: doc/BRIEF.md
# LIN Break Detector

This block watches a serial receive line and reports a break, meaning a low level that lasts longer than any valid all-zero data character can. The line is examined only on a sample tick supplied from outside, which arrives sixteen times per bit time. Consecutive low ticks are counted. When the count reaches the active threshold, a sticky break flag is raised.

A LIN-mode input raises the threshold from ten to eleven bit times. Before synchronization, a slave's clock may differ from the master's by up to ±15%. Under that mismatch, an all-zero data byte can appear as long as about 10.35 local bit times, and a genuine 13-bit break can appear as short as about 11.05 local bit times. The higher threshold separates the two cases. In LIN mode, a low run that ends after more than ten bit times but before the LIN threshold sets a sticky framing-error flag instead of a break.

When each low run ends, its length is latched in whole bit times so that software can make its own final length check. After a break is reported, no further break is reported until the line has been high for a full bit time.

Top module: `lin_break_detector`

## Requirements
- R1: Reset clears the break flag, the framing-error flag and the measured length, and leaves detection armed.
- R2: With LIN mode off, the break flag rises after the 160th consecutive low sample tick (ten bit times). It stays low after 159.
- R3: With LIN mode on, the break flag rises after the 176th consecutive low sample tick (eleven bit times). It stays low after 175, including for a stretched all-zero byte of about 166 ticks.
- R4: When the first high tick after a low run arrives, the length output latches floor(low ticks / 16). The tick counter saturates at 1023, so the length saturates at 63. Otherwise the length holds its value.
- R5: The break flag is sticky and a one-cycle clear pulse drops it. If the clear arrives in the same cycle that a break is detected, the flag is set.
- R6: After a break, no further break is reported until sixteen consecutive high ticks have been seen. A low run that starts before then is never flagged, whatever its length.
- R7: With LIN mode on and detection armed, a low run that ends with between 161 and 175 low ticks sets the sticky framing-error flag. A run of 160 or fewer does not. The clear pulse drops the flag.
- R8: The line is ignored in cycles without a sample tick. Low time without ticks adds nothing to the count or the length.
- R9: With LIN mode off, a long low run gives a break and never a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial receive line |
| tick_i | input | 1 | Sample tick, 16 per bit time |
| lin_en_i | input | 1 | Selects the LIN-tolerant break threshold |
| clr_i | input | 1 | One-cycle pulse that clears both flags |
| brk_o | output | 1 | Sticky break flag |
| fe_o | output | 1 | Sticky framing-error flag |
| low_bits_o | output | LEN_W | Length of the last low run in whole bit times |

## Verification
The bench probes each threshold one tick below and exactly at its value. A design that is off by one would flag a 159-tick run or miss a 176-tick run. It sends a stretched all-zero byte in LIN mode: a design that applied the short threshold there would report a false break instead of a framing error. It starts a new low run after only fifteen high ticks following a break, which catches a detector that re-arms on the first high sample. It also lands a clear pulse on the detecting tick, holds the line low without ticks, and runs past counter saturation. These cases expose lost events, counting on idle cycles and length wrap-around.

// File: rtl/lin_break_detector.sv
module lin_break_detector #(
  parameter int TPB      = 16,
  parameter int LEN_W    = 6,
  parameter int STD_BITS = 10,
  parameter int LIN_BITS = 11,
  parameter int FE_BITS  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             tick_i,
  input  logic             lin_en_i,
  input  logic             clr_i,
  output logic             brk_o,
  output logic             fe_o,
  output logic [LEN_W-1:0] low_bits_o
);
  localparam int SH     = $clog2(TPB);
  localparam int CNT_W  = LEN_W + SH;
  localparam int HI_W   = SH + 1;
  localparam int STD_TH = STD_BITS * TPB;
  localparam int LIN_TH = LIN_BITS * TPB;
  localparam int FE_TH  = FE_BITS * TPB;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  hi_cnt;
  logic             armed;

  wire low_tick  = tick_i & ~rx_i;
  wire high_tick = tick_i &  rx_i;
  wire run_end   = high_tick && (cnt != '0);

  wire [CNT_W-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire [HI_W-1:0]  hi_inc  = (hi_cnt >= HI_W'(TPB)) ? hi_cnt : hi_cnt + 1'b1;
  wire [CNT_W-1:0] thr     = lin_en_i ? CNT_W'(LIN_TH) : CNT_W'(STD_TH);

  wire brk_set = low_tick && armed && (cnt_inc >= thr);
  wire fe_set  = run_end && armed && lin_en_i && (cnt > CNT_W'(FE_TH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      hi_cnt     <= '0;
      armed      <= 1'b1;
      brk_o      <= 1'b0;
      fe_o       <= 1'b0;
      low_bits_o <= '0;
    end else begin
      if (low_tick) begin
        cnt    <= cnt_inc;
        hi_cnt <= '0;
      end else if (high_tick) begin
        hi_cnt <= hi_inc;
        if (run_end) begin
          cnt        <= '0;
          low_bits_o <= cnt[CNT_W-1:SH];
        end
      end

      if (brk_set)
        armed <= 1'b0;
      else if (high_tick && hi_inc >= HI_W'(TPB))
        armed <= 1'b1;

      if (brk_set)    brk_o <= 1'b1;
      else if (clr_i) brk_o <= 1'b0;

      if (fe_set)     fe_o <= 1'b1;
      else if (clr_i) fe_o <= 1'b0;
    end
  end

  AST_BRK_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_o) |-> ($past(cnt_inc) >= $past(thr))); // R2
  AST_BRK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_o) |-> $past(armed)); // R6
  AST_CLR_DROPS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !brk_set) |=> !brk_o); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(cnt) && $stable(low_bits_o))); // R8
  AST_LEN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !run_end |=> $stable(low_bits_o)); // R4
  AST_FE_NEEDS_LIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_o) |-> $past(lin_en_i)); // R7
endmodule

// File: tb/lin_break_detector_bench.sv
module lin_break_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b0, lin_en = 1'b0, clr = 1'b0;
  logic brk, fe;
  logic [LEN_W-1:0] low_bits;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_break_detector #(.LEN_W(LEN_W)) u_lin_break_detector (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .lin_en_i(lin_en),
    .clr_i(clr), .brk_o(brk), .fe_o(fe), .low_bits_o(low_bits));

  task automatic step(input logic r, input logic t, input logic c);
    @(negedge clk);
    rx = r; tick = t; clr = c;
  endtask

  task automatic send(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      step(lvl, 1'b1, 1'b0);
      step(lvl, 1'b0, 1'b0);
    end
  endtask

  task automatic pulse_clr();
    step(rx, 1'b0, 1'b1);
    step(rx, 1'b0, 1'b0);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    send(1'b1, 20);
    pulse_clr();
  endtask

  task automatic t_reset();
    chk("R1 brk", brk, 0);
    chk("R1 fe", fe, 0);
    chk("R1 len", low_bits, 0);
  endtask

  task automatic t_std_threshold();
    lin_en = 1'b0;
    send(1'b0, 159);
    chk("R2 no brk at 159", brk, 0);
    send(1'b0, 1);
    chk("R2 brk at 160", brk, 1);
    send(1'b1, 20);
    chk("R4 len 160", low_bits, 10);
    chk("R9 no fe", fe, 0);
    pulse_clr();
    chk("R5 clr", brk, 0);
  endtask

  task automatic t_lin_threshold();
    lin_en = 1'b1;
    send(1'b0, 175);
    chk("R3 no brk at 175", brk, 0);
    send(1'b0, 1);
    chk("R3 brk at 176", brk, 1);
    send(1'b1, 20);
    chk("R4 len 176", low_bits, 11);
    chk("R7 no fe on break", fe, 0);
    settle();
  endtask

  task automatic t_stretched_zero();
    lin_en = 1'b1;
    send(1'b0, 166);
    send(1'b1, 20);
    chk("R3 stretched zero no brk", brk, 0);
    chk("R7 stretched zero fe", fe, 1);
    chk("R4 len 166", low_bits, 10);
    pulse_clr();
    chk("R7 fe cleared", fe, 0);
  endtask

  task automatic t_fe_boundary();
    lin_en = 1'b1;
    send(1'b0, 160);
    send(1'b1, 20);
    chk("R7 160 no fe", fe, 0);
    send(1'b0, 161);
    send(1'b1, 20);
    chk("R7 161 fe", fe, 1);
    settle();
  endtask

  task automatic t_std_long();
    lin_en = 1'b0;
    send(1'b0, 200);
    send(1'b1, 20);
    chk("R9 long brk", brk, 1);
    chk("R9 long no fe", fe, 0);
    chk("R4 len 200", low_bits, 12);
    settle();
  endtask

  task automatic t_set_wins();
    lin_en = 1'b0;
    send(1'b0, 159);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R5 set wins over clr", brk, 1);
    settle();
  endtask

  task automatic t_rearm();
    lin_en = 1'b0;
    send(1'b0, 160);
    chk("R6 first brk", brk, 1);
    pulse_clr();
    send(1'b1, 15);
    send(1'b0, 170);
    chk("R6 suppressed", brk, 0);
    send(1'b1, 16);
    send(1'b0, 160);
    chk("R6 rearmed", brk, 1);
    settle();
  endtask

  task automatic t_no_tick();
    lin_en = 1'b0;
    send(1'b0, 20);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b0);
    chk("R8 idle no brk", brk, 0);
    send(1'b1, 2);
    chk("R8 len ignores idle", low_bits, 1);
    send(1'b0, 5);
    send(1'b1, 2);
    chk("R4 short run len 0", low_bits, 0);
  endtask

  task automatic t_saturate();
    lin_en = 1'b0;
    send(1'b0, 1100);
    send(1'b1, 20);
    chk("R4 saturated len", low_bits, 63);
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std_threshold();
    t_lin_threshold();
    t_stretched_zero();
    t_fe_boundary();
    t_std_long();
    t_set_wins();
    t_rearm();
    t_no_tick();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule